// File: doc/BRIEF.md
# Age-Counter Way Replacement Tracker

This block holds the replacement state for a set-associative cache, one set at a time. Every way of every set carries a small age counter. The highest count value marks the most recent use, and zero marks the stalest or an empty way. A cache controller presents a lookup with a set index and a hit or miss flag. On a hit it also gives the way that matched. On a miss the block names the way to refill on `victim_way`, and that name is formed combinationally from the stored counters of the addressed set. When the lookup strobe is high, the counters of that set are updated at the next rising clock edge.

The controller can also clear the age of a single way, or of every way in a set, through a separate invalidate port. A cleared way is then the first choice for replacement. The block stores no tags and no data, and it has no bus interface. Two build-time parameters set its shape: the number of counter states, from 2 to 4, and the way count, a power of two.

Top module: `age_repl_tracker`

## Requirements
- R1: After synchronous active-high reset, every counter of every set is zero, so `victim_way` reads 0 for any `lookup_set`.
- R2: `USTATES` may be 2, 3 or 4, and the most-recent value is `USTATES-1`. `WAYS` must be a power of two no larger than `MAX_WAYS`. Any other value stops elaboration.
- R3: On a strobed hit to way W, every way of that set whose counter is strictly greater than W's counter drops by one, and W is set to the most-recent value.
- R4: `victim_way` is the lowest-numbered way holding the smallest counter in set `lookup_set`. When every counter is at the most-recent value, this gives way 0.
- R5: On a strobed miss, every way of that set with a nonzero counter drops by one, and then the victim way reported in that cycle is set to the most-recent value.
- R6: An invalidate with `inv_whole_set`=0 clears only counter `inv_way` of set `inv_set`.
- R7: An invalidate with `inv_whole_set`=1 clears every counter of set `inv_set`.
- R8: A lookup and an invalidate aimed at different sets both take effect at the same edge. A miss and an invalidate aimed at the same set apply the miss update first and then the clear.
- R9: A hit and an invalidate to the same set in the same cycle are illegal input.
- R10: When `lookup_valid` and `inv_valid` are both low, no counter changes, whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lookup_valid | input | 1 | Update strobe for a lookup |
| lookup_hit | input | 1 | 1 = hit, 0 = miss |
| lookup_set | input | SET_W | Set index of the lookup; also selects the set for `victim_way` |
| lookup_way | input | WAY_W | Matching way on a hit |
| inv_valid | input | 1 | Invalidate request |
| inv_whole_set | input | 1 | 1 = clear all ways of the set, 0 = clear one way |
| inv_set | input | SET_W | Set index of the invalidate |
| inv_way | input | WAY_W | Way to clear when `inv_whole_set` is 0 |
| victim_way | output | WAY_W | Replacement choice for `lookup_set` |

## Verification
The bench builds the tracker with 4 ways, 8 sets and 3 counter states. With three states, ties between ways happen often, which exercises the lowest-index rule. Because the maximum value is 2, counters bump into both zero and the top value within a few accesses, and this brings the nonzero-only decrement on a miss within reach. A mix of directed sequences and long random traffic over the eight sets exercises invalidates and lookups that share a cycle, on the same set and on different sets.

// File: rtl/age_repl_pkg.sv
package age_repl_pkg;

  typedef enum logic [1:0] {
    UPD_NONE = 2'd0,
    UPD_HIT  = 2'd1,
    UPD_MISS = 2'd2
  } upd_op_e;

  function automatic int ctr_bits(input int states);
    return (states > 2) ? 2 : 1;
  endfunction

endpackage

// File: rtl/repl_victim_pick.sv
module repl_victim_pick #(
  parameter int WAYS  = 4,
  parameter int CW    = 2,
  parameter int WAY_W = 2
) (
  input  logic [WAYS*CW-1:0] ages_i,
  output logic [WAY_W-1:0]   victim_o
);
  logic [CW-1:0]    best_val;
  logic [WAY_W-1:0] best_idx;

  // strict less-than keeps the earliest way on ties
  always_comb begin
    best_val = ages_i[CW-1:0];
    best_idx = '0;
    for (int i = 1; i < WAYS; i++) begin
      if (ages_i[i*CW +: CW] < best_val) begin
        best_val = ages_i[i*CW +: CW];
        best_idx = WAY_W'(i);
      end
    end
  end

  assign victim_o = best_idx;
endmodule

// File: rtl/repl_age_update.sv
module repl_age_update
  import age_repl_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int CW    = 2,
  parameter int WAY_W = 2,
  parameter int TOPV  = 3
) (
  input  upd_op_e            op_i,
  input  logic [WAY_W-1:0]   way_i,
  input  logic               clr_en_i,
  input  logic               clr_all_i,
  input  logic [WAY_W-1:0]   clr_way_i,
  input  logic [WAY_W-1:0]   pad_i,
  input  logic [WAYS*CW-1:0] ages_i,
  output logic [WAYS*CW-1:0] ages_o
);
  localparam logic [CW-1:0] TOP = CW'(TOPV);

  logic [CW-1:0] ref_age;
  logic [CW-1:0] cur;
  logic          unused_pad;

  assign unused_pad = ^pad_i;
  assign ref_age    = ages_i[way_i*CW +: CW];

  always_comb begin
    ages_o = ages_i;
    for (int i = 0; i < WAYS; i++) begin
      cur = ages_i[i*CW +: CW];
      unique case (op_i)
        UPD_HIT:  if (cur > ref_age) ages_o[i*CW +: CW] = cur - 1'b1;
        UPD_MISS: if (cur != '0)     ages_o[i*CW +: CW] = cur - 1'b1;
        default:  ;
      endcase
    end
    if (op_i != UPD_NONE) ages_o[way_i*CW +: CW] = TOP;
    if (clr_en_i) begin
      if (clr_all_i) ages_o = '0;
      else           ages_o[clr_way_i*CW +: CW] = '0;
    end
  end
endmodule

// File: rtl/age_repl_tracker.sv
module age_repl_tracker
  import age_repl_pkg::*;
#(
  parameter int WAYS     = 4,
  parameter int MAX_WAYS = 8,
  parameter int SETS     = 16,
  parameter int USTATES  = 4,
  localparam int WAY_W   = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int SET_W   = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lookup_valid,
  input  logic             lookup_hit,
  input  logic [SET_W-1:0] lookup_set,
  input  logic [WAY_W-1:0] lookup_way,
  input  logic             inv_valid,
  input  logic             inv_whole_set,
  input  logic [SET_W-1:0] inv_set,
  input  logic [WAY_W-1:0] inv_way,
  output logic [WAY_W-1:0] victim_way
);
  localparam int CW   = ctr_bits(USTATES);
  localparam int TOPV = USTATES - 1;
  localparam int ROWW = WAYS * CW;

  // R2: reject shapes the counters cannot represent
  generate
    if (USTATES < 2 || USTATES > 4) begin : g_bad_states
      $error("USTATES must be 2, 3 or 4");
    end
    if (WAYS < 2 || WAYS > MAX_WAYS || (WAYS & (WAYS - 1)) != 0) begin : g_bad_ways
      $error("WAYS must be a power of two between 2 and MAX_WAYS");
    end
  endgenerate

  logic [ROWW-1:0]  age_mem [SETS];
  logic [ROWW-1:0]  lk_row;
  logic [ROWW-1:0]  iv_row;
  logic [ROWW-1:0]  lk_next;
  logic [ROWW-1:0]  iv_next;
  logic [WAY_W-1:0] pick;
  logic [WAY_W-1:0] promote_way;
  logic             same_set;
  upd_op_e          lk_op;

  assign lk_row   = age_mem[lookup_set];
  assign iv_row   = age_mem[inv_set];
  assign same_set = inv_valid && lookup_valid && (inv_set == lookup_set);

  always_comb begin
    if (!lookup_valid)  lk_op = UPD_NONE;
    else if (lookup_hit) lk_op = UPD_HIT;
    else                 lk_op = UPD_MISS;
  end

  assign promote_way = lookup_hit ? lookup_way : pick;

  repl_victim_pick #(.WAYS(WAYS), .CW(CW), .WAY_W(WAY_W)) u_pick (
    .ages_i   (lk_row),
    .victim_o (pick)
  );

  // lookup path; folds in a clear aimed at the same set (R8)
  repl_age_update #(.WAYS(WAYS), .CW(CW), .WAY_W(WAY_W), .TOPV(TOPV)) u_lk_upd (
    .op_i      (lk_op),
    .way_i     (promote_way),
    .clr_en_i  (same_set),
    .clr_all_i (inv_whole_set),
    .clr_way_i (inv_way),
    .pad_i     (lookup_way),
    .ages_i    (lk_row),
    .ages_o    (lk_next)
  );

  // invalidate path for a set the lookup does not touch
  repl_age_update #(.WAYS(WAYS), .CW(CW), .WAY_W(WAY_W), .TOPV(TOPV)) u_iv_upd (
    .op_i      (UPD_NONE),
    .way_i     (inv_way),
    .clr_en_i  (1'b1),
    .clr_all_i (inv_whole_set),
    .clr_way_i (inv_way),
    .pad_i     (inv_way),
    .ages_i    (iv_row),
    .ages_o    (iv_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) age_mem[s] <= '0;
    end else begin
      if (inv_valid && !same_set) age_mem[inv_set]    <= iv_next;
      if (lookup_valid)           age_mem[lookup_set] <= lk_next;
    end
  end

  assign victim_way = pick;
endmodule

// File: rtl/age_repl_checker.sv
module age_repl_checker #(
  parameter int WAY_W = 2,
  parameter int SET_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             lookup_valid,
  input logic             lookup_hit,
  input logic [SET_W-1:0] lookup_set,
  input logic [WAY_W-1:0] lookup_way,
  input logic             inv_valid,
  input logic             inv_whole_set,
  input logic [SET_W-1:0] inv_set,
  input logic [WAY_W-1:0] inv_way,
  input logic [WAY_W-1:0] victim_way
);

  assert_no_hit_inv_clash_R9: assert property (@(posedge clk) disable iff (rst)
    (lookup_valid && lookup_hit && inv_valid) |-> (inv_set != lookup_set));

  assert_hit_way_not_victim_R3: assert property (@(posedge clk) disable iff (rst)
    (lookup_valid && lookup_hit)
    |=> (lookup_set != $past(lookup_set) || victim_way != $past(lookup_way)));

  assert_miss_promotes_victim_R5: assert property (@(posedge clk) disable iff (rst)
    (lookup_valid && !lookup_hit && !(inv_valid && inv_set == lookup_set))
    |=> (lookup_set != $past(lookup_set) || victim_way != $past(victim_way)));

  assert_way_clear_preferred_R6: assert property (@(posedge clk) disable iff (rst)
    (inv_valid && !inv_whole_set)
    |=> (lookup_set != $past(inv_set) || victim_way <= $past(inv_way)));

  assert_set_clear_way0_R7: assert property (@(posedge clk) disable iff (rst)
    (inv_valid && inv_whole_set)
    |=> (lookup_set != $past(inv_set) || victim_way == '0));

endmodule

bind age_repl_tracker age_repl_checker #(.WAY_W(WAY_W), .SET_W(SET_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .lookup_valid  (lookup_valid),
  .lookup_hit    (lookup_hit),
  .lookup_set    (lookup_set),
  .lookup_way    (lookup_way),
  .inv_valid     (inv_valid),
  .inv_whole_set (inv_whole_set),
  .inv_set       (inv_set),
  .inv_way       (inv_way),
  .victim_way    (victim_way)
);

// File: tb/sim_age_repl_tracker.sv
module sim_age_repl_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int WAYS    = 4;
  localparam int SETS    = 8;
  localparam int USTATES = 3;
  localparam int WAY_W   = 2;
  localparam int SET_W   = 3;
  localparam int TOPV    = USTATES - 1;
  localparam int WATCHDOG = 100000;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             lookup_valid = 1'b0, lookup_hit = 1'b0;
  logic [SET_W-1:0] lookup_set = '0;
  logic [WAY_W-1:0] lookup_way = '0;
  logic             inv_valid = 1'b0, inv_whole_set = 1'b0;
  logic [SET_W-1:0] inv_set = '0;
  logic [WAY_W-1:0] inv_way = '0;
  logic [WAY_W-1:0] victim_way;

  int model [SETS][WAYS];
  int total = 0;
  int bad   = 0;
  int cycles = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  age_repl_tracker #(.WAYS(WAYS), .MAX_WAYS(8), .SETS(SETS), .USTATES(USTATES)) u0 (
    .clk(clk), .rst(rst),
    .lookup_valid(lookup_valid), .lookup_hit(lookup_hit),
    .lookup_set(lookup_set), .lookup_way(lookup_way),
    .inv_valid(inv_valid), .inv_whole_set(inv_whole_set),
    .inv_set(inv_set), .inv_way(inv_way),
    .victim_way(victim_way)
  );

  function automatic int ref_victim(input int s);
    int b = 0;
    for (int i = 1; i < WAYS; i++) if (model[s][i] < model[s][b]) b = i;
    return b;
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: victim_way=%0d expected=%0d", tag, got, exp);
    end
  endtask

  // drive at negedge, compare the combinational victim, then advance the model at posedge
  task automatic step(input bit lv, input bit hit, input int ls, input int lw,
                      input bit iv, input bit iall, input int is, input int iw,
                      input string tag);
    int v;
    @(negedge clk);
    lookup_valid = lv; lookup_hit = hit;
    lookup_set = SET_W'(ls); lookup_way = WAY_W'(lw);
    inv_valid = iv; inv_whole_set = iall;
    inv_set = SET_W'(is); inv_way = WAY_W'(iw);
    #1;
    v = ref_victim(ls);
    check(tag, int'(victim_way), v);
    @(posedge clk);
    if (lv) begin
      if (hit) begin
        int h = model[ls][lw];
        for (int i = 0; i < WAYS; i++) if (model[ls][i] > h) model[ls][i]--;
        model[ls][lw] = TOPV;
      end else begin
        for (int i = 0; i < WAYS; i++) if (model[ls][i] != 0) model[ls][i]--;
        model[ls][v] = TOPV;
      end
    end
    if (iv) begin
      if (iall) for (int i = 0; i < WAYS; i++) model[is][i] = 0;
      else model[is][iw] = 0;
    end
  endtask

  task automatic peek(input int s, input string tag);
    step(1'b0, 1'b0, s, 0, 1'b0, 1'b0, 0, 0, tag);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        bad++; total++;
        $display("FAIL watchdog: cycles=%0d expected<=%0d", cycles, WATCHDOG);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    for (int s = 0; s < SETS; s++) for (int w = 0; w < WAYS; w++) model[s][w] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1: every set starts with victim 0
    for (int s = 0; s < SETS; s++) peek(s, "R1 reset");

    // R4 R5 R2: miss chain in set 2 fills ways in order, max value 2
    for (int k = 0; k < 6; k++) step(1'b1, 1'b0, 2, 0, 1'b0, 1'b0, 0, 0, "R5 miss chain");
    peek(2, "R4 lowest min after misses");
    peek(2, "R2 top value held");

    // R3: hits with relative decrement
    step(1'b1, 1'b1, 2, 0, 1'b0, 1'b0, 0, 0, "R3 hit way0");
    step(1'b1, 1'b1, 2, 3, 1'b0, 1'b0, 0, 0, "R3 hit way3");
    step(1'b1, 1'b1, 2, 3, 1'b0, 1'b0, 0, 0, "R3 rehit top");
    peek(2, "R3 after hits");

    // R4: drive all ways of set 5 to top is impossible by design; check ties by hits only
    for (int w = 0; w < WAYS; w++) step(1'b1, 1'b1, 5, w, 1'b0, 1'b0, 0, 0, "R4 hit sweep");
    peek(5, "R4 tie lowest");

    // R6 R7: clears
    step(1'b0, 1'b0, 2, 0, 1'b1, 1'b0, 2, 3, "R6 clear way3");
    peek(2, "R6 cleared way wins");
    step(1'b0, 1'b0, 5, 0, 1'b1, 1'b1, 5, 0, "R7 clear set");
    peek(5, "R7 whole set cleared");

    // R8: different sets same edge, and miss+clear same set
    step(1'b1, 1'b0, 1, 0, 1'b1, 1'b0, 2, 0, "R8 split sets");
    peek(1, "R8 lookup side");
    peek(2, "R8 clear side");
    step(1'b1, 1'b0, 1, 0, 1'b1, 1'b0, 1, 1, "R8 miss then clear");
    peek(1, "R8 same set order");

    // R10: idle cycles with noisy fields change nothing
    for (int k = 0; k < 8; k++)
      step(1'b0, k[0], k % SETS, k % WAYS, 1'b0, k[1], (k + 1) % SETS, (k + 2) % WAYS, "R10 idle");
    for (int s = 0; s < SETS; s++) peek(s, "R10 state kept");

    // random traffic; hit+clear on one set avoided (R9)
    for (int k = 0; k < 4000; k++) begin
      bit lv = ($urandom % 4) != 0;
      bit hit = $urandom % 2;
      int ls = $urandom % SETS;
      int lw = $urandom % WAYS;
      bit iv = ($urandom % 5) == 0;
      bit ia = ($urandom % 3) == 0;
      int is = $urandom % SETS;
      int iw = $urandom % WAYS;
      if (lv && hit && iv && is == ls) is = (ls + 1) % SETS;
      step(lv, hit, ls, lw, iv, ia, is, iw, "R3 R5 R6 R8 random");
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule